// File: doc/BRIEF.md
# Strap Property Resolver

This block turns an 8-bit strap code, already sampled from four two-level strapping pins, into a 32-bit board property word. Each pin contributes two bits. The upper bit of each pair is set when that pin has an external pull-up. The bits fall into a low group (bits 3:0) and a high group (bits 7:4), one for each host-bus wiring. The block first checks that at least one pull-up indicator is present. It then picks the bus group whose indicators are set and clears the other group's bits, so that weak pull-downs that read unreliably on the unused pins cannot spoil the lookup. The masked code is compared against a table of known board configurations. Codes with no pull-up, and valid codes that match no entry, fall back to a property set chosen by bus type.

A persistent property register keeps its value across soft resets. It supplies the held value. When that value still carries strap-related bits and no hard reset occurred, the block reuses it as is. Otherwise only the strap-related field is rebuilt, and the other bits are left alone. A table match also writes the result back to the persistent register in three steps: open the write enable, write the data, close the write enable.

Top module: `strap_prop_resolver`

## Requirements
- R1: While reset is asserted and in the first cycle after it, propWord is 0 and propValid, regWeSet, regWrite and regWeClr are all low.
- R2: When codeValid is sampled high on an edge with no write sequence in progress, propWord takes the resolved value on that edge and propValid is high for exactly the following cycle. propWord does not change at any other time.
- R3: Property flags sit at fixed bit positions: SPI host bus bit 0, I2C host bus bit 1, USB-to-host bit 2, reset-line pull-up needed bit 3, platform reset used bit 4. Bits 4:0 form the strap-related field (mask 0x1F).
- R4: If heldProps has any bit of the field 0x1F set and hardReset is low, propWord equals heldProps exactly and no write sequence starts.
- R5: When properties are rebuilt, propWord bits 31:5 equal heldProps bits 31:5, and bits 4:0 come only from the strap resolution.
- R6: If code AND 0xAA is zero, the field is 0x12 (I2C plus platform reset) and no write sequence starts.
- R7: If code AND 0x0A is nonzero, the code is masked with 0x0F before lookup. Otherwise it is masked with 0xF0. Bits in the unused group never affect the result.
- R8: A masked code of 0x02 resolves the field to 0x09 (SPI plus reset-line pull-up). A masked code of 0x20 resolves it to 0x16 (I2C, USB-to-host, platform reset).
- R9: A code with a pull-up that matches no table entry resolves the field to 0x01 when the low group holds the pull-up, and to 0x12 otherwise. No write sequence starts.
- R10: On a rebuilt table match, regWeSet is high in the cycle where propValid is high. regWrite is high in the next cycle with regWrData equal to propWord. regWeClr is high in the cycle after that. All three are then low.
- R11: codeValid is ignored while a write sequence is in progress: propValid stays low and propWord is unchanged.
- R12: hardReset high forces a rebuild even when heldProps already has strap-related bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| codeValid | input | 1 | Strobe: strapCode, heldProps and hardReset are valid |
| strapCode | input | 8 | Raw strap code, two bits per pin |
| hardReset | input | 1 | Last reset was a hard reset |
| heldProps | input | 32 | Current value of the persistent property register |
| propWord | output | 32 | Resolved property word |
| propValid | output | 1 | One-cycle pulse: propWord was just updated |
| regWeSet | output | 1 | Step 1: open the persistent register write enable |
| regWrite | output | 1 | Step 2: write regWrData into the persistent register |
| regWeClr | output | 1 | Step 3: close the persistent register write enable |
| regWrData | output | 32 | Data for the persistent register write |

## Verification
The assertions assume that strapCode, heldProps and hardReset are steady in the cycle where codeValid is sampled. The reuse and upper-bit properties compare propWord against the previous cycle's heldProps, so they depend on this. They also assume that heldProps does not change in response to the block's own write until the sequence has closed. The directed tasks drive every input together on a falling edge, raise codeValid for one cycle, and hold the other inputs until the task has checked the whole sequence. One task raises codeValid on purpose during an open write sequence, to show that the strobe is dropped.

// File: rtl/strap_pkg.sv
package strap_pkg;

  localparam int CODE_W = 8;
  localparam int PROP_W = 32;

  // Property flag positions (behaviour depends on them)
  localparam int BIT_SPI       = 0;
  localparam int BIT_I2C       = 1;
  localparam int BIT_USB_HOST  = 2;
  localparam int BIT_RST_PULL  = 3;
  localparam int BIT_PLT_RESET = 4;

  localparam logic [PROP_W-1:0] FLAG_SPI       = PROP_W'(1) << BIT_SPI;
  localparam logic [PROP_W-1:0] FLAG_I2C       = PROP_W'(1) << BIT_I2C;
  localparam logic [PROP_W-1:0] FLAG_USB_HOST  = PROP_W'(1) << BIT_USB_HOST;
  localparam logic [PROP_W-1:0] FLAG_RST_PULL  = PROP_W'(1) << BIT_RST_PULL;
  localparam logic [PROP_W-1:0] FLAG_PLT_RESET = PROP_W'(1) << BIT_PLT_RESET;

  localparam logic [PROP_W-1:0] STRAP_FIELD =
    FLAG_SPI | FLAG_I2C | FLAG_USB_HOST | FLAG_RST_PULL | FLAG_PLT_RESET;
  localparam logic [PROP_W-1:0] FALLBACK_PROPS = FLAG_I2C | FLAG_PLT_RESET;

  // Strap code masks: upper bit of every pair flags an external pull-up
  localparam logic [CODE_W-1:0] PULLUP_SEL   = 8'hAA;
  localparam logic [CODE_W-1:0] LOW_PULL_SEL = 8'h0A;
  localparam logic [CODE_W-1:0] LOW_KEEP     = 8'h0F;
  localparam logic [CODE_W-1:0] HIGH_KEEP    = 8'hF0;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_OPEN  = 2'd1,
    SEQ_WRITE = 2'd2,
    SEQ_CLOSE = 2'd3
  } seqState_t;

endpackage

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
#(
  parameter int NUM_ENTRIES = 2,
  parameter logic [NUM_ENTRIES*CODE_W-1:0] ENTRY_CODES = {8'h20, 8'h02},
  parameter logic [NUM_ENTRIES*PROP_W-1:0] ENTRY_PROPS =
    {FLAG_I2C | FLAG_USB_HOST | FLAG_PLT_RESET, FLAG_SPI | FLAG_RST_PULL}
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [CODE_W-1:0] strapCode,
  input  logic              hardReset,
  input  logic [PROP_W-1:0] heldProps,
  output logic              needWrite,
  output logic [PROP_W-1:0] propWord
);

  logic [CODE_W-1:0]      pullBits;
  logic                   anyPull;
  logic                   lowGroup;
  logic [CODE_W-1:0]      maskedCode;
  logic [NUM_ENTRIES-1:0] entryHit;
  logic                   tableHit;
  logic [PROP_W-1:0]      tableProps;
  logic [PROP_W-1:0]      freshBits;
  logic                   rebuild;
  logic [PROP_W-1:0]      resolved;

  assign pullBits   = strapCode & PULLUP_SEL;
  assign anyPull    = |pullBits;
  assign lowGroup   = |(pullBits & LOW_PULL_SEL);
  assign maskedCode = lowGroup ? (strapCode & LOW_KEEP) : (strapCode & HIGH_KEEP);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ENTRIES; gi++) begin : gEntry
      assign entryHit[gi] = (maskedCode == ENTRY_CODES[gi*CODE_W +: CODE_W]);
    end
  endgenerate

  assign tableHit = |entryHit;

  // Lowest-index entry wins when several match
  always_comb begin
    tableProps = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (entryHit[i]) tableProps = ENTRY_PROPS[i*PROP_W +: PROP_W];
    end
  end

  always_comb begin
    if (!anyPull)       freshBits = FALLBACK_PROPS;
    else if (tableHit)  freshBits = tableProps;
    else if (lowGroup)  freshBits = FLAG_SPI;
    else                freshBits = FALLBACK_PROPS;
  end

  assign rebuild  = hardReset || ((heldProps & STRAP_FIELD) == '0);
  assign resolved = rebuild ? ((heldProps & ~STRAP_FIELD) | (freshBits & STRAP_FIELD))
                            : heldProps;
  assign needWrite = rebuild && anyPull && tableHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             propWord <= '0;
    else if (strobes.load) propWord <= resolved;
  end

endmodule

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         codeValid,
  input  logic         needWrite,
  output ctrlStrobes_t strobes,
  output logic         propValid,
  output logic         regWeSet,
  output logic         regWrite,
  output logic         regWeClr
);

  seqState_t state, stateNext;

  assign strobes.load = codeValid && (state == SEQ_IDLE);

  always_comb begin
    stateNext = state;
    unique case (state)
      SEQ_IDLE:  if (strobes.load && needWrite) stateNext = SEQ_OPEN;
      SEQ_OPEN:  stateNext = SEQ_WRITE;
      SEQ_WRITE: stateNext = SEQ_CLOSE;
      SEQ_CLOSE: stateNext = SEQ_IDLE;
      default:   stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      propValid <= 1'b0;
    end else begin
      state     <= stateNext;
      propValid <= strobes.load;
    end
  end

  assign regWeSet = (state == SEQ_OPEN);
  assign regWrite = (state == SEQ_WRITE);
  assign regWeClr = (state == SEQ_CLOSE);

endmodule

// File: rtl/strap_prop_resolver.sv
module strap_prop_resolver
  import strap_pkg::*;
#(
  parameter int NUM_ENTRIES = 2,
  parameter logic [NUM_ENTRIES*CODE_W-1:0] ENTRY_CODES = {8'h20, 8'h02},
  parameter logic [NUM_ENTRIES*PROP_W-1:0] ENTRY_PROPS =
    {FLAG_I2C | FLAG_USB_HOST | FLAG_PLT_RESET, FLAG_SPI | FLAG_RST_PULL}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              codeValid,
  input  logic [CODE_W-1:0] strapCode,
  input  logic              hardReset,
  input  logic [PROP_W-1:0] heldProps,
  output logic [PROP_W-1:0] propWord,
  output logic              propValid,
  output logic              regWeSet,
  output logic              regWrite,
  output logic              regWeClr,
  output logic [PROP_W-1:0] regWrData
);

  ctrlStrobes_t strobes;
  logic         needWrite;

  strap_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .codeValid (codeValid),
    .needWrite (needWrite),
    .strobes   (strobes),
    .propValid (propValid),
    .regWeSet  (regWeSet),
    .regWrite  (regWrite),
    .regWeClr  (regWeClr)
  );

  strap_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ENTRY_CODES (ENTRY_CODES),
    .ENTRY_PROPS (ENTRY_PROPS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .strapCode (strapCode),
    .hardReset (hardReset),
    .heldProps (heldProps),
    .needWrite (needWrite),
    .propWord  (propWord)
  );

  assign regWrData = propWord;

endmodule

// File: rtl/strap_prop_resolver_checker.sv
module strap_prop_resolver_checker (
  input logic        clk,
  input logic        rstN,
  input logic        codeValid,
  input logic        hardReset,
  input logic [31:0] heldProps,
  input logic [31:0] propWord,
  input logic        propValid,
  input logic        regWeSet,
  input logic        regWrite,
  input logic        regWeClr,
  input logic [31:0] regWrData
);

  assert_valid_after_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    propValid |-> $past(codeValid));

  assert_word_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    !propValid |-> $stable(propWord));

  assert_reuse_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (propValid && !$past(hardReset) && (($past(heldProps) & 32'h1F) != 32'h0))
      |-> (propWord == $past(heldProps)));

  assert_upper_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    propValid |-> (propWord[31:5] == $past(heldProps[31:5])));

  assert_open_with_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    regWeSet |-> propValid);

  assert_open_then_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    regWeSet |=> regWrite);

  assert_write_then_close_R10: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |=> regWeClr);

  assert_close_then_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    regWeClr |=> !(regWeSet || regWrite || regWeClr));

  assert_one_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWeSet, regWrite, regWeClr}));

  assert_write_data_steady_R10: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |-> ($stable(regWrData) && (regWrData[4:0] != 5'h0)));

  assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite || regWeClr) |-> !propValid);

endmodule

bind strap_prop_resolver strap_prop_resolver_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .codeValid (codeValid),
  .hardReset (hardReset),
  .heldProps (heldProps),
  .propWord  (propWord),
  .propValid (propValid),
  .regWeSet  (regWeSet),
  .regWrite  (regWrite),
  .regWeClr  (regWeClr),
  .regWrData (regWrData)
);

// File: tb/strap_prop_resolver_tb.sv
module strap_prop_resolver_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        codeValid = 1'b0;
  logic [7:0]  strapCode = '0;
  logic        hardReset = 1'b0;
  logic [31:0] heldProps = '0;
  logic [31:0] propWord;
  logic        propValid;
  logic        regWeSet;
  logic        regWrite;
  logic        regWeClr;
  logic [31:0] regWrData;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_prop_resolver dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .codeValid (codeValid),
    .strapCode (strapCode),
    .hardReset (hardReset),
    .heldProps (heldProps),
    .propWord  (propWord),
    .propValid (propValid),
    .regWeSet  (regWeSet),
    .regWrite  (regWrite),
    .regWeClr  (regWeClr),
    .regWrData (regWrData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // One code through the block; checks word, pulse and write sequence
  task automatic runCase(input string req, input logic [7:0] c,
                         input logic [31:0] held, input bit hr,
                         input logic [31:0] expWord, input bit expWrite);
    @(negedge clk);
    strapCode = c; heldProps = held; hardReset = hr; codeValid = 1'b1;
    @(negedge clk);
    codeValid = 1'b0;
    check(propValid == 1'b1, {req, " valid pulse (R2)"}, 32'(propValid), 32'd1);
    check(propWord == expWord, {req, " word"}, propWord, expWord);
    check(regWeSet == expWrite, {req, " open step (R10)"}, 32'(regWeSet), 32'(expWrite));
    @(negedge clk);
    check(propValid == 1'b0, {req, " pulse ends (R2)"}, 32'(propValid), 32'd0);
    if (expWrite) begin
      check(regWrite == 1'b1, {req, " write step (R10)"}, 32'(regWrite), 32'd1);
      check(regWrData == expWord, {req, " write data (R10)"}, regWrData, expWord);
      @(negedge clk);
      check(regWeClr == 1'b1, {req, " close step (R10)"}, 32'(regWeClr), 32'd1);
      @(negedge clk);
      check({regWeSet, regWrite, regWeClr} == 3'b000, {req, " idle after (R10)"},
            32'({regWeSet, regWrite, regWeClr}), 32'd0);
    end else begin
      check({regWeSet, regWrite, regWeClr} == 3'b000, {req, " no write"},
            32'({regWeSet, regWrite, regWeClr}), 32'd0);
    end
  endtask

  task automatic testReset();
    check(propWord == 32'h0, "R1 reset word", propWord, 32'h0);
    check({propValid, regWeSet, regWrite, regWeClr} == 4'h0, "R1 reset flags",
          32'({propValid, regWeSet, regWrite, regWeClr}), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(propWord == 32'h0, "R1 word after release", propWord, 32'h0);
    check({propValid, regWeSet, regWrite, regWeClr} == 4'h0, "R1 flags after release",
          32'({propValid, regWeSet, regWrite, regWeClr}), 32'h0);
  endtask

  task automatic testBusyIgnore();
    @(negedge clk);
    strapCode = 8'h02; heldProps = 32'h0; hardReset = 1'b0; codeValid = 1'b1;
    @(negedge clk);
    check(regWeSet == 1'b1, "R11 sequence opened", 32'(regWeSet), 32'd1);
    strapCode = 8'h55;  // would give 0x12 if accepted
    @(negedge clk);
    check(propValid == 1'b0, "R11 no pulse while busy", 32'(propValid), 32'd0);
    check(propWord == 32'h9, "R11 word kept", propWord, 32'h9);
    @(negedge clk);
    codeValid = 1'b0;
    check(propValid == 1'b0, "R11 no pulse at close", 32'(propValid), 32'd0);
    check(propWord == 32'h9, "R11 word still kept", propWord, 32'h9);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    testReset();
    runCase("R8 SPI entry 0x02 (R3 bits 0,3)",      8'h02, 32'h0, 1'b0, 32'h00000009, 1'b1);
    runCase("R8 I2C entry 0x20 (R3 bits 1,2,4)",    8'h20, 32'h0, 1'b0, 32'h00000016, 1'b1);
    runCase("R7 high-group noise masked 0x62",      8'h62, 32'h0, 1'b0, 32'h00000009, 1'b1);
    runCase("R7 low-group noise masked 0x21",       8'h21, 32'h0, 1'b0, 32'h00000016, 1'b1);
    runCase("R6 no pull-up 0x55",                   8'h55, 32'h0, 1'b0, 32'h00000012, 1'b0);
    runCase("R6 no pull-up 0x00",                   8'h00, 32'h0, 1'b0, 32'h00000012, 1'b0);
    runCase("R9 unmatched low group 0x0A",          8'h0A, 32'h0, 1'b0, 32'h00000001, 1'b0);
    runCase("R9 unmatched high group 0x80",         8'h80, 32'h0, 1'b0, 32'h00000012, 1'b0);
    runCase("R5 upper bits kept",                   8'h02, 32'hA0000000, 1'b0, 32'hA0000009, 1'b1);
    runCase("R4 held bits reused",                  8'h20, 32'h00000108, 1'b0, 32'h00000108, 1'b0);
    runCase("R12 hard reset rebuilds",              8'h20, 32'h00000108, 1'b1, 32'h00000116, 1'b1);
    testBusyIgnore();
    runCase("R2 accepted after busy",               8'h0A, 32'h0, 1'b0, 32'h00000001, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule